// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

This block is a watchdog for a processor subsystem. Software reaches it through a simple register bus: a byte address, a write enable, 32-bit write data and combinational 32-bit read data. Software sets a reload value and enables the counter. It must then keep writing a 16-bit key to the restart register before the counter runs out. If the counter reaches zero while enabled, the block drives a system reset pulse of programmable length and latches a timeout flag. After the pulse the counter reloads and keeps guarding the system.

The counter steps down by one on every bus clock, or only on cycles where the external 1 MHz tick enable is high, as chosen by a control bit. The live count can be read back at any time. The restart register takes the key only in its low half-word, so software that writes a full word with extra upper bits still restarts the counter.

Register offsets (byte addresses, word aligned):

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | live count | read only |
| 0x04 | reload value | read/write |
| 0x08 | restart key | write only |
| 0x0C | control: bit 0 = run, bit 4 = time base | read/write |
| 0x10 | timeout flag in bit 0 | read only |
| 0x14 | flag clear | write only |
| 0x18 | reset pulse length in bits 7:0 | read/write |

Top module: `keyed_watchdog`

## Requirements
- R1: After the active-low asynchronous reset, reads return 0 for the count (0x00), 0x00FFFFFF for the reload value (0x04), 0 for control (0x0C) and 0 for the flag (0x10). `sys_rst` is low.
- R2: A write to 0x04 stores the reload value. A write to 0x0C stores all 32 bits. A write to 0x18 stores bits 7:0. Each reads back from the same offset.
- R3: A control write that sets bit 0 while the stored bit 0 is 0 loads the counter with the reload value at that clock edge. The count reads back at 0x00.
- R4: While control bit 0 is 1, the count drops by one on each clock edge. With control bit 4 at 0 this happens on every edge. With control bit 4 at 1 it happens only on edges where `tick_1us` is high.
- R5: A write to 0x08 whose bits 15:0 equal 0x4755 reloads the counter from the reload value, whatever bits 31:16 hold. A write to 0x08 with any other low half-word leaves the count unchanged.
- R6: While control bit 0 is 0, the count holds its value regardless of ticks.
- R7: If the count is 0 at a clock edge while enabled, `sys_rst` goes high at that edge. It stays high for N clocks, where N is bits 7:0 of 0x18, or 1 if that field is 0. At the edge that ends the pulse, the counter reloads if still enabled.
- R8: The edge that starts the reset pulse sets bit 0 of 0x10. Any write to 0x14 clears it.
- R9: Reads of 0x08 and 0x14 return 0. Writes to 0x00 leave the count unchanged.
- R10: Reads of any address outside 0x00 to 0x18, or not word aligned, return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle enable at the 1 MHz rate |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst | output | 1 | System reset pulse on expiry |

## Verification
The bench writes a restart with the wrong key and then one with the right key plus junk in the upper half-word. A design that compares all 32 bits, or accepts any value, gives a wrong count at one of the two reads. With the 1 MHz base selected it counts exact tick pulses, so a design that ignores the base bit loses many counts at once. It samples `sys_rst` on every cycle around expiry with a 3-cycle width and a 0 width, which catches a pulse that is one cycle off or an empty pulse for width 0. It reads the count right after the pulse to prove the reload, and reads aliased and out-of-window addresses to catch decoding that drops address bits.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int unsigned KWD_WINDOW_BYTES = 32;
  localparam int unsigned KWD_RUN_BIT      = 0;
  localparam int unsigned KWD_BASE_BIT     = 4;
  localparam logic [15:0] KWD_KEY_DEFAULT  = 16'h4755;

  // register slot selected by a word-aligned byte address inside the window
  typedef enum logic [2:0] {
    SEL_COUNT  = 3'd0,
    SEL_RELOAD = 3'd1,
    SEL_KICK   = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_FLAG   = 3'd4,
    SEL_ACK    = 3'd5,
    SEL_WIDTH  = 3'd6,
    SEL_NONE   = 3'd7
  } kwd_sel_e;

  function automatic logic kwd_key_match(input logic [31:0] data, input logic [15:0] key);
    return data[15:0] == key;
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PW_W   = 8,
  parameter logic [15:0] KEY    = KWD_KEY_DEFAULT,
  parameter logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(32'h00FF_FFFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              expire,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload_val,
  output logic              ctrl_run,
  output logic              ctrl_base,
  output logic [PW_W-1:0]   width_val,
  output logic              flag_q,
  output logic              load_evt
);
  localparam logic [ADDR_W-1:0] WINDOW_END = ADDR_W'(KWD_WINDOW_BYTES);

  function automatic kwd_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a[1:0] != 2'b00 || a >= WINDOW_END) return SEL_NONE;
    return kwd_sel_e'(a[4:2]);
  endfunction

  kwd_sel_e          sel;
  logic [DATA_W-1:0] ctrl_q;
  logic              kick_ok;
  logic              run_rise;

  assign sel      = decode(addr);
  assign kick_ok  = we && (sel == SEL_KICK) && kwd_key_match(32'(wdata), KEY);
  assign run_rise = we && (sel == SEL_CTRL) && wdata[KWD_RUN_BIT] && !ctrl_q[KWD_RUN_BIT];
  assign load_evt = kick_ok || run_rise;

  assign ctrl_run  = ctrl_q[KWD_RUN_BIT];
  assign ctrl_base = ctrl_q[KWD_BASE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_val <= RELOAD_INIT;
      ctrl_q     <= '0;
      width_val  <= '0;
      flag_q     <= 1'b0;
    end else begin
      if (we && sel == SEL_RELOAD) reload_val <= wdata[CNT_W-1:0];
      if (we && sel == SEL_CTRL)   ctrl_q     <= wdata;
      if (we && sel == SEL_WIDTH)  width_val  <= wdata[PW_W-1:0];
      if (expire)                       flag_q <= 1'b1;
      else if (we && sel == SEL_ACK)    flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_COUNT:  rdata = DATA_W'(cnt_val);
      SEL_RELOAD: rdata = DATA_W'(reload_val);
      SEL_CTRL:   rdata = ctrl_q;
      SEL_FLAG:   rdata = DATA_W'(flag_q);
      SEL_WIDTH:  rdata = DATA_W'(width_val);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwd_tick_sel.sv
module kwd_tick_sel (
  input  logic run,
  input  logic base_slow,
  input  logic tick_1us,
  output logic step
);
  assign step = run && (base_slow ? tick_1us : 1'b1);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             run,
  input  logic             step,
  input  logic [PW_W-1:0]  width_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pulsing,
  output logic             expire,
  output logic             pulse_done
);
  logic [PW_W-1:0] pw_left;

  function automatic logic [PW_W-1:0] pulse_len(input logic [PW_W-1:0] w);
    return (w == '0) ? PW_W'(1) : w;
  endfunction

  function automatic logic [CNT_W-1:0] count_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - CNT_W'(1);
  endfunction

  assign expire     = run && !pulsing && !load_evt && (cnt_q == '0);
  assign pulse_done = pulsing && (pw_left == PW_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulsing <= 1'b0;
      pw_left <= '0;
    end else begin
      if (load_evt)                cnt_q <= reload_val;
      else if (pulse_done && run)  cnt_q <= reload_val;
      else if (step && !pulsing)   cnt_q <= count_down(cnt_q);

      if (expire) begin
        pulsing <= 1'b1;
        pw_left <= pulse_len(width_val);
      end else if (pulse_done) begin
        pulsing <= 1'b0;
      end else if (pulsing) begin
        pw_left <= pw_left - PW_W'(1);
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PW_W   = 8,
  parameter logic [15:0] KEY    = KWD_KEY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_val;
  logic [PW_W-1:0]  width_val;
  logic             ctrl_run;
  logic             ctrl_base;
  logic             flag_q;
  logic             load_evt;
  logic             step;
  logic             expire;
  logic             pulse_done;

  kwd_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PW_W(PW_W), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .cnt_val(cnt_q), .expire(expire), .rdata(bus_rdata), .reload_val(reload_val),
    .ctrl_run(ctrl_run), .ctrl_base(ctrl_base), .width_val(width_val),
    .flag_q(flag_q), .load_evt(load_evt)
  );

  kwd_tick_sel u_tick (
    .run(ctrl_run), .base_slow(ctrl_base), .tick_1us(tick_1us), .step(step)
  );

  kwd_counter #(.CNT_W(CNT_W), .PW_W(PW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .reload_val(reload_val),
    .run(ctrl_run), .step(step), .width_val(width_val), .cnt_q(cnt_q),
    .pulsing(sys_rst), .expire(expire), .pulse_done(pulse_done)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter logic [15:0] KEY    = 16'h4755
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1us,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              sys_rst,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ctrl_run,
  input logic              ctrl_base,
  input logic              flag_q,
  input logic              load_evt,
  input logic              expire,
  input logic              pulse_done
);
  // count moves only by one step down, or by a reload
  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_evt) || $past(pulse_done) || cnt_q == $past(cnt_q) ||
    cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_slow_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_run && ctrl_base && !tick_1us && !load_evt && !pulse_done) |=> cnt_q == $past(cnt_q));

  assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8) && bus_wdata[15:0] != KEY && !ctrl_run) |=> cnt_q == $past(cnt_q));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_run && !load_evt) |=> cnt_q == $past(cnt_q));

  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(expire));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (flag_q && sys_rst));

  assert_kick_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8)) |-> bus_rdata == '0);
endmodule

bind keyed_watchdog kwd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst(sys_rst), .cnt_q(cnt_q),
  .ctrl_run(ctrl_run), .ctrl_base(ctrl_base), .flag_q(flag_q), .load_evt(load_evt),
  .expire(expire), .pulse_done(pulse_done)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
  localparam int unsigned WD_CYCLES = 20000;

  typedef struct {
    bit          is_rst;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1us = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst;

  item_t sb_q[$];
  bit    mon_req = 1'b0;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst(sys_rst)
  );

  // monitor: pops the expected item and compares it against the pins
  always @(negedge clk) begin
    if (mon_req && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_rst ? {31'b0, sys_rst} : bus_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_rst = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic expect_rst(input bit e, input string tag);
    item_t it;
    it.is_rst = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_1us = 1'b1;
    for (int i = 1; i < n; i++) begin
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    tick_1us = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd(8'h00, 32'h0, "R1 count");
    expect_rd(8'h04, 32'h00FF_FFFF, "R1 reload");
    expect_rd(8'h0C, 32'h0, "R1 control");
    expect_rd(8'h10, 32'h0, "R1 flag");
    expect_rst(1'b0, "R1 sys_rst");

    // R2 readback, R3 load on enable (slow base, no ticks)
    wr(8'h04, 32'd100);
    expect_rd(8'h04, 32'd100, "R2 reload");
    wr(8'h0C, 32'h0000_0011);
    expect_rd(8'h0C, 32'h0000_0011, "R2 control");
    expect_rd(8'h00, 32'd100, "R3 load on enable");

    // R4 slow base counts exactly the tick pulses
    ticks(3);
    expect_rd(8'h00, 32'd97, "R4 slow base");

    // R5 key checking
    wr(8'h08, 32'h1234_4756);
    expect_rd(8'h00, 32'd97, "R5 wrong key");
    wr(8'h08, 32'hABCD_4755);
    expect_rd(8'h00, 32'd100, "R5 right key");

    // R9 write-only reads and read-only writes
    expect_rd(8'h08, 32'h0, "R9 restart read");
    expect_rd(8'h14, 32'h0, "R9 clear read");
    wr(8'h00, 32'd5);
    expect_rd(8'h00, 32'd100, "R9 count write");

    // R10 outside the window
    wr(8'h44, 32'd7);
    wr(8'h06, 32'd9);
    expect_rd(8'h04, 32'd100, "R10 alias write");
    expect_rd(8'h44, 32'h0, "R10 read far");
    expect_rd(8'h1C, 32'h0, "R10 read hole");
    expect_rd(8'h05, 32'h0, "R10 read unaligned");

    // R6 disabled counter ignores ticks
    wr(8'h0C, 32'h0000_0010);
    ticks(5);
    expect_rd(8'h00, 32'd100, "R6 frozen");

    // R7 fast base expiry with width 3
    wr(8'h04, 32'd10);
    wr(8'h18, 32'h0000_AB03);
    expect_rd(8'h18, 32'h03, "R2 width");
    wr(8'h0C, 32'h0000_0001);
    for (int k = 0; k < 15; k++)
      expect_rst((k >= 11) && (k <= 13), $sformatf("R7 pulse cycle %0d", k));
    expect_rd(8'h00, 32'd9, "R7 reload after pulse");
    expect_rd(8'h10, 32'h1, "R8 flag set");

    // R8 clear
    wr(8'h0C, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    expect_rd(8'h10, 32'h0, "R8 flag clear");

    // R7 width 0 gives one cycle
    wr(8'h04, 32'd2);
    wr(8'h18, 32'h0);
    wr(8'h0C, 32'h0000_0001);
    for (int k = 0; k < 5; k++)
      expect_rst(k == 3, $sformatf("R7 min width cycle %0d", k));
    wr(8'h0C, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule